// File: doc/BRIEF.md
# Packet Header Inserter

This block puts a programmable header of up to 24 bytes in front of every datagram that passes through it. Before traffic starts, a host loads a header template and a small set of field descriptors through a simple write port. A datagram arrives as a byte stream with valid/ready handshaking and start/end markers. The block holds the whole payload in a local store and patches four dynamic values into its copy of the template. It then sends the finished header followed by the payload on an output stream of the same kind.

The four dynamic values are the total length, a 16-bit one's-complement checksum, a 16-bit sequence number and a 32-bit timestamp. The host chooses where each one sits and, for three of them, how many bytes it occupies. One engine can therefore build the headers of several layer-4/5 protocols. The payload is stored before the header goes out, so the length and the checksum are final when the first header byte leaves.

Top module: `hdr_splicer`

## Requirements
- R1: A write to address 32 sets the header length from cfg_wdata[7:0]. Values above 24 saturate to 24. Each packet leaves as exactly that many header bytes followed by the stored payload, with out_sop on its first byte and out_eop on its last. A header length of 0 sends the payload alone.
- R2: A write to an address A in 0..23 stores cfg_wdata[7:0] as template byte A. Header byte A goes out as that template byte when no enabled field covers it.
- R3: The length field (descriptor at address 33) holds the header length plus the number of stored payload bytes.
- R4: The sequence field (descriptor at address 35) holds a 16-bit counter. A write to address 37 loads the counter with cfg_wdata[15:0]. The counter steps by one, modulo 2^16, at the handshake of each packet's last output byte, and a packet carries the value from before its own step.
- R5: The timestamp field (descriptor at address 36) holds a 32-bit counter that is 0 during reset and rises by one every clock. Its value is captured at the clock edge that accepts the in_sop byte.
- R6: The checksum field (descriptor at address 34) is always 2 bytes wide, whatever its width bits say. It holds the bitwise inverse of the 16-bit one's-complement sum over the header-then-payload byte stream. The stream is read as 16-bit words with the even-position byte as the upper half, and an odd final byte is padded with zero. The checksum bytes count as zero in the sum, and the other fields count with their patched values.
- R7: A descriptor word uses cfg_wdata bits [4:0] for the byte offset, [6:5] for the width minus one (1 to 4 bytes) and bit 7 for enable. The low width bytes of the field value are written most significant first, starting at the offset. A disabled field leaves the template bytes unchanged, and field bytes at or past the header length are dropped.
- R8: Where enabled fields overlap, the checksum wins over the length, the length over the sequence and the sequence over the timestamp.
- R9: in_ready is high only while a packet is being received, and out_valid is never high at the same time. While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold their values.
- R10: At most 256 payload bytes are stored. Further bytes before in_eop are accepted but discarded and are not counted in the length.
- R11: After reset, out_valid is 0, in_ready is 1, the sequence counter is 0, the header length is 0 and every field is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 6 | Host write address |
| cfg_wdata | input | 16 | Host write data |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | First payload byte of a datagram |
| in_eop | input | 1 | Last payload byte of a datagram |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte, header then payload |
| out_sop | output | 1 | First byte of an output packet |
| out_eop | output | 1 | Last byte of an output packet |

## Verification
The timestamp is the counter value at the edge that accepts the in_sop byte. The bench therefore keeps its own cycle count under the same reset and reads it on the falling edge just before that acceptance. After the edge that takes in_eop, the block spends one cycle per header byte adding up the header, plus one folding cycle. out_valid therefore rises header-length-plus-one edges later, and the sequence counter steps on the edge of the last output handshake. The scoreboard depends only on byte order. It pushes the full expected packet on the eop acceptance edge, well before any output can appear. It compares bytes on falling edges and changes out_ready just after rising edges, so a stalled byte is checked on the next falling edge for being held.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    parameter int HDR_MAX = 24;
    parameter int PAY_MAX = 256;
    localparam int HL_W = $clog2(HDR_MAX + 1);
    localparam int PC_W = $clog2(PAY_MAX + 1);
    localparam int PA_W = $clog2(PAY_MAX);
    localparam int NFLD = 4;

    // host address map
    localparam logic [5:0] A_HLEN = 6'd32;
    localparam logic [5:0] A_LEN  = 6'd33;
    localparam logic [5:0] A_CKS  = 6'd34;
    localparam logic [5:0] A_SEQ  = 6'd35;
    localparam logic [5:0] A_TS   = 6'd36;
    localparam logic [5:0] A_SEQ0 = 6'd37;

    // field index doubles as overlap priority: higher index wins
    typedef enum logic [1:0] {
        F_TS  = 2'd0,
        F_SEQ = 2'd1,
        F_LEN = 2'd2,
        F_CKS = 2'd3
    } fld_e;

    typedef struct packed {
        logic       en;
        logic [1:0] wm1;
        logic [4:0] off;
    } fdesc_t;

    typedef enum logic [1:0] {
        S_RECV,
        S_HSUM,
        S_HDR,
        S_PAY
    } st_e;

    function automatic logic fld_hit(fdesc_t d, logic [HL_W-1:0] idx);
        logic [6:0] lo;
        logic [6:0] hi;
        logic [6:0] i;
        lo = {2'b00, d.off};
        hi = lo + {5'b0, d.wm1} + 7'd1;
        i  = 7'(idx);
        return d.en && (i >= lo) && (i < hi);
    endfunction

    // byte k of the field (k = idx - off) is value byte (wm1 - k), MSB first
    function automatic logic [7:0] fld_byte(fdesc_t d, logic [31:0] val,
                                            logic [HL_W-1:0] idx);
        logic [6:0] k;
        logic [1:0] sh;
        k  = 7'(idx) - {2'b00, d.off};
        sh = d.wm1 - k[1:0];
        return 8'(val >> {sh, 3'b000});
    endfunction

    function automatic logic [31:0] word_part(logic [7:0] b, logic odd);
        return odd ? {24'b0, b} : {16'b0, b, 8'b0};
    endfunction

    function automatic logic [15:0] ocsum_fold(logic [31:0] s);
        logic [16:0] a;
        logic [16:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = {1'b0, a[15:0]} + {16'b0, a[16]};
        return b[15:0];
    endfunction
endpackage

// File: rtl/hsp_cfg.sv
module hsp_cfg
    import hsp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [5:0]               cfg_addr,
    input  logic [15:0]              cfg_wdata,
    output logic [HDR_MAX-1:0][7:0]  tmpl,
    output logic [HL_W-1:0]          hdr_len,
    output fdesc_t [NFLD-1:0]        desc,
    output logic                     seq_load,
    output logic [15:0]              seq_start
);
    fdesc_t wd;
    assign wd        = fdesc_t'(cfg_wdata[7:0]);
    assign seq_load  = cfg_we && (cfg_addr == A_SEQ0);
    assign seq_start = cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmpl    <= '0;
            hdr_len <= '0;
            desc    <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < HDR_MAX; i++) begin
                if (cfg_addr == 6'(i)) tmpl[i] <= cfg_wdata[7:0];
            end
            case (cfg_addr)
                A_HLEN: hdr_len <= (cfg_wdata[7:0] > 8'(HDR_MAX)) ? HL_W'(HDR_MAX)
                                                                 : cfg_wdata[HL_W-1:0];
                A_LEN:  desc[F_LEN] <= wd;
                A_CKS:  desc[F_CKS] <= '{en: wd.en, wm1: 2'd1, off: wd.off};
                A_SEQ:  desc[F_SEQ] <= wd;
                A_TS:   desc[F_TS]  <= wd;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hsp_cnt.sv
module hsp_cnt (
    input  logic        clk,
    input  logic        rst,
    input  logic        seq_load,
    input  logic [15:0] seq_start,
    input  logic        pkt_done,
    output logic [15:0] seq_q,
    output logic [31:0] ts_now
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ts_now <= '0;
            seq_q  <= '0;
        end else begin
            ts_now <= ts_now + 32'd1;
            if (seq_load)      seq_q <= seq_start;
            else if (pkt_done) seq_q <= seq_q + 16'd1;
        end
    end
endmodule

// File: rtl/hsp_pay_buf.sv
module hsp_pay_buf #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hsp_patch.sv
module hsp_patch
    import hsp_pkg::*;
(
    input  logic [HDR_MAX-1:0][7:0]  tmpl,
    input  fdesc_t [NFLD-1:0]        desc,
    input  logic [NFLD-1:0][31:0]    vals,
    input  logic [HL_W-1:0]          idx,
    input  logic                     zero_cks,
    output logic [7:0]               pbyte
);
    logic [NFLD-1:0]      hit;
    logic [NFLD-1:0][7:0] fb;

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign hit[f] = fld_hit(desc[f], idx);
        if (f == int'(F_CKS)) begin : g_cks
            assign fb[f] = zero_cks ? 8'h00 : fld_byte(desc[f], vals[f], idx);
        end else begin : g_val
            assign fb[f] = fld_byte(desc[f], vals[f], idx);
        end
    end

    always_comb begin
        pbyte = (32'(idx) < HDR_MAX) ? tmpl[idx] : 8'h00;
        for (int f = 0; f < NFLD; f++) begin
            if (hit[f]) pbyte = fb[f];
        end
    end
endmodule

// File: rtl/hdr_splicer.sv
module hdr_splicer
    import hsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop
);
    logic [HDR_MAX-1:0][7:0] tmpl;
    logic [HL_W-1:0]         hdr_len;
    fdesc_t [NFLD-1:0]       desc;
    logic                    seq_load;
    logic [15:0]             seq_start;
    logic [15:0]             seq_q;
    logic [31:0]             ts_now;

    st_e                     st;
    logic [HL_W-1:0]         idx;
    logic [PC_W-1:0]         pcnt;
    logic [PC_W-1:0]         rdidx;
    logic [31:0]             sum;
    logic [31:0]             ts_cap;
    logic [15:0]             cks_q;
    logic                    acc;
    logic                    pkt_done;
    logic                    we;
    logic [PA_W-1:0]         waddr;
    logic [7:0]              rbyte;
    logic [7:0]              pbyte;
    logic [NFLD-1:0][31:0]   vals;

    hsp_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tmpl(tmpl), .hdr_len(hdr_len), .desc(desc),
        .seq_load(seq_load), .seq_start(seq_start)
    );

    hsp_cnt u_cnt (
        .clk(clk), .rst(rst), .seq_load(seq_load), .seq_start(seq_start),
        .pkt_done(pkt_done), .seq_q(seq_q), .ts_now(ts_now)
    );

    hsp_pay_buf #(.DEPTH(PAY_MAX)) u_buf (
        .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
        .raddr(rdidx[PA_W-1:0]), .rdata(rbyte)
    );

    hsp_patch u_patch (
        .tmpl(tmpl), .desc(desc), .vals(vals), .idx(idx),
        .zero_cks(st == S_HSUM), .pbyte(pbyte)
    );

    always_comb begin
        vals        = '0;
        vals[F_TS]  = ts_cap;
        vals[F_SEQ] = {16'b0, seq_q};
        vals[F_LEN] = 32'(hdr_len) + 32'(pcnt);
        vals[F_CKS] = {16'b0, cks_q};
    end

    assign in_ready  = (st == S_RECV);
    assign acc       = in_valid && in_ready;
    assign waddr     = in_sop ? '0 : pcnt[PA_W-1:0];
    assign we        = acc && (in_sop || (pcnt < PC_W'(PAY_MAX)));

    assign out_valid = (st == S_HDR) || (st == S_PAY);
    assign out_data  = (st == S_HDR) ? pbyte : rbyte;
    assign out_sop   = ((st == S_HDR) && (idx == '0)) ||
                       ((st == S_PAY) && (hdr_len == '0) && (rdidx == '0));
    assign out_eop   = (st == S_PAY) && (rdidx == pcnt - PC_W'(1));
    assign pkt_done  = out_valid && out_ready && out_eop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_RECV;
            idx    <= '0;
            pcnt   <= '0;
            rdidx  <= '0;
            sum    <= '0;
            ts_cap <= '0;
            cks_q  <= '0;
        end else begin
            case (st)
                S_RECV: if (acc) begin
                    if (in_sop) begin
                        ts_cap <= ts_now;
                        pcnt   <= PC_W'(1);
                        sum    <= word_part(in_data, hdr_len[0]);
                    end else if (pcnt < PC_W'(PAY_MAX)) begin
                        pcnt <= pcnt + PC_W'(1);
                        sum  <= sum + word_part(in_data, hdr_len[0] ^ pcnt[0]);
                    end
                    if (in_eop) begin
                        st  <= S_HSUM;
                        idx <= '0;
                    end
                end
                S_HSUM: begin
                    if (idx < hdr_len) begin
                        sum <= sum + word_part(pbyte, idx[0]);
                        idx <= idx + HL_W'(1);
                    end else begin
                        cks_q <= ~ocsum_fold(sum);
                        idx   <= '0;
                        rdidx <= '0;
                        st    <= (hdr_len == '0) ? S_PAY : S_HDR;
                    end
                end
                S_HDR: if (out_ready) begin
                    if (idx == hdr_len - HL_W'(1)) st <= S_PAY;
                    else idx <= idx + HL_W'(1);
                end
                S_PAY: if (out_ready) begin
                    if (rdidx == pcnt - PC_W'(1)) st <= S_RECV;
                    rdidx <= rdidx + PC_W'(1);
                end
                default: st <= S_RECV;
            endcase
        end
    end
endmodule

// File: rtl/hsp_chk.sv
module hsp_chk
    import hsp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_data,
    input logic            out_sop,
    input logic            out_eop,
    input logic [15:0]     seq_q,
    input logic [31:0]     ts_now,
    input logic [HL_W-1:0] hdr_len,
    input logic [PC_W-1:0] pcnt,
    input logic            cfg_we,
    input logic [5:0]      cfg_addr
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_sop) && $stable(out_eop)));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eop && !(cfg_we && cfg_addr == A_SEQ0))
        |=> (seq_q == $past(seq_q) + 16'd1));

    // R5
    ts_run_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ts_now == $past(ts_now) + 32'd1));

    // R1
    hlen_cap_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_len <= HL_W'(HDR_MAX));

    // R10
    pcnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= PC_W'(PAY_MAX));

    // R1
    eop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eop) |=> !out_valid);
endmodule

bind hdr_splicer hsp_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .seq_q(seq_q), .ts_now(ts_now), .hdr_len(hdr_len),
    .pcnt(pcnt), .cfg_we(cfg_we), .cfg_addr(cfg_addr)
);

// File: tb/sim_hdr_splicer.sv
module sim_hdr_splicer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sop;
    logic        out_eop;

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] tb_cyc;
    bit          bp = 1'b0;
    bit          hold_v = 1'b0;
    logic [9:0]  hold_w;
    logic [9:0]  exp_q[$];
    string       tag_q[$];

    // bench model of the configuration
    int          tmpl_m[24];
    int          hlen_m = 0;
    bit          en_m[4];
    int          off_m[4];
    int          w_m[4];
    int          seq_m = 0;
    // field order: 0 timestamp, 1 sequence, 2 length, 3 checksum (rising priority)
    int          faddr[4] = '{36, 35, 33, 34};
    string       ftag[4]  = '{"R5", "R4", "R3", "R6"};

    always #4 clk = ~clk;

    hdr_splicer u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    always @(posedge clk) begin
        if (rst) tb_cyc <= '0;
        else     tb_cyc <= tb_cyc + 32'd1;
    end

    always @(posedge clk) begin
        #1 out_ready = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every output handshake
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_v)
                chk(out_valid && ({out_sop, out_eop, out_data} == hold_w), "R9",
                    {out_valid, out_sop, out_eop, out_data}, {1'b1, hold_w});
            if (out_valid && out_ready) begin
                chk(!in_ready, "R9", in_ready, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", {out_sop, out_eop, out_data}, 0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_sop, out_eop, out_data} == e, t,
                        {out_sop, out_eop, out_data}, e);
                end
            end
            hold_v = out_valid && !out_ready;
            hold_w = {out_sop, out_eop, out_data};
        end
    end

    task automatic cfg_wr(int a, int d);
        @(negedge clk);
        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 6'(a);
        cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_tmpl(int a, int v);
        cfg_wr(a, v);
        tmpl_m[a] = v & 255;
    endtask

    task automatic set_hlen(int v);
        cfg_wr(32, v);
        hlen_m = (v > 24) ? 24 : v;
    endtask

    task automatic set_fld(int f, bit en, int off, int w);
        cfg_wr(faddr[f], (int'(en) << 7) | (((w - 1) & 3) << 5) | (off & 31));
        en_m[f]  = en;
        off_m[f] = off;
        w_m[f]   = (f == 3) ? 2 : w;
    endtask

    task automatic set_seq0(int v);
        cfg_wr(37, v);
        seq_m = v & 65535;
    endtask

    task automatic send_pkt(int n, int seed, string tag);
        logic [7:0] pay[$];
        logic [7:0] h[24];
        string      tg[24];
        longint     vals[4];
        longint     s;
        longint     ck;
        int         ns;
        int         tot;
        longint     ts_v;
        ts_v = 0;
        for (int i = 0; i < n; i++) pay.push_back(8'((seed + i * 37) & 255));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pay[i];
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
            while (!in_ready) @(negedge clk);
            if (i == 0) ts_v = longint'(tb_cyc);
            @(posedge clk);
        end
        // expected packet, built from the requirements
        ns  = (n > 256) ? 256 : n;
        tot = hlen_m + ns;
        vals[0] = ts_v;
        vals[1] = seq_m;
        vals[2] = tot;
        vals[3] = 0;
        for (int k = 0; k < hlen_m; k++) begin
            h[k]  = 8'(tmpl_m[k]);
            tg[k] = "R2";
        end
        for (int f = 0; f < 4; f++) begin
            if (en_m[f]) begin
                for (int k = 0; k < w_m[f]; k++) begin
                    int p;
                    p = off_m[f] + k;
                    if (p < hlen_m) begin
                        h[p]  = 8'((vals[f] >> (8 * (w_m[f] - 1 - k))) & 255);
                        tg[p] = ftag[f];
                    end
                end
            end
        end
        s = 0;
        for (int j = 0; j < tot; j++) begin
            longint b;
            b = (j < hlen_m) ? longint'(h[j]) : longint'(pay[j - hlen_m]);
            s += (j % 2 == 0) ? (b << 8) : b;
        end
        while ((s >> 16) != 0) s = (s & 65535) + (s >> 16);
        ck = (~s) & 65535;
        if (en_m[3]) begin
            for (int k = 0; k < 2; k++) begin
                int p;
                p = off_m[3] + k;
                if (p < hlen_m) h[p] = 8'((k == 0) ? (ck >> 8) : (ck & 255));
            end
        end
        for (int j = 0; j < tot; j++) begin
            logic [7:0] d;
            d = (j < hlen_m) ? h[j] : pay[j - hlen_m];
            exp_q.push_back({(j == 0), (j == tot - 1), d});
            tag_q.push_back((tag != "") ? tag : ((j < hlen_m) ? tg[j] : "R1"));
        end
        seq_m = (seq_m + 1) & 65535;
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state at the ports
        chk(out_valid == 1'b0, "R11", out_valid, 0);
        chk(in_ready == 1'b1, "R11", in_ready, 1);
        // R11: zero header length and no fields after reset
        send_pkt(4, 3, "R11");

        for (int k = 0; k < 24; k++) set_tmpl(k, 8'hA0 + k);
        // R11: sequence starts at 0
        set_hlen(8);
        set_fld(1, 1'b1, 0, 2);
        send_pkt(5, 1, "R11");
        // R7: disabled field keeps template bytes
        set_fld(1, 1'b0, 0, 2);
        send_pkt(7, 2, "R7");
        send_pkt(3, 9, "R2");

        // all four fields, sequence wrap (R3 R4 R5 R6)
        set_hlen(20);
        set_fld(2, 1'b1, 2, 2);
        set_fld(3, 1'b1, 6, 2);
        set_fld(1, 1'b1, 10, 2);
        set_fld(0, 1'b1, 12, 4);
        set_seq0(16'hFFFE);
        for (int i = 0; i < 3; i++) send_pkt(17 + i, 10 + i, "");
        send_pkt(40, 77, "");

        // R8 overlap priority
        set_fld(0, 1'b1, 0, 4);
        set_fld(3, 1'b1, 0, 2);
        set_fld(2, 1'b1, 3, 2);
        set_fld(1, 1'b1, 4, 2);
        send_pkt(9, 5, "R8");

        // R7: field bytes past the header end are dropped
        set_hlen(6);
        set_fld(3, 1'b0, 0, 2);
        set_fld(2, 1'b0, 0, 2);
        set_fld(1, 1'b0, 0, 2);
        set_fld(0, 1'b1, 4, 4);
        send_pkt(4, 21, "R7");

        // R1: empty header, then saturation of the length write
        set_hlen(0);
        send_pkt(6, 33, "R1");
        set_hlen(30);
        set_fld(2, 1'b1, 22, 2);
        send_pkt(3, 44, "R1");

        // R10: oversize payload
        set_hlen(4);
        set_fld(0, 1'b0, 0, 4);
        set_fld(2, 1'b1, 0, 2);
        send_pkt(300, 55, "R10");

        // R9: output back-pressure
        set_hlen(12);
        set_fld(0, 1'b1, 0, 4);
        set_fld(1, 1'b1, 4, 2);
        set_fld(2, 1'b1, 6, 2);
        set_fld(3, 1'b1, 8, 2);
        bp = 1'b1;
        send_pkt(25, 66, "R9");
        send_pkt(8, 88, "R9");
        while (exp_q.size() != 0) @(negedge clk);
        bp = 1'b0;
        repeat (5) @(negedge clk);
        chk(!out_valid && exp_q.size() == 0, "R1", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule